// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the modem control register of a 16550-compatible serial port and produces its modem status register. Software writes a five-bit control word, and the unit drives it onto the DTR, RTS, OUT1 and OUT2 output pins. The four incoming handshake lines are synchronised into the clock domain: CTS (clear to send), DSR (data set ready), DCD (carrier detect) and RI (ring indicator). The unit compares each synchronised line with the value it last recorded. A change sets a sticky delta flag. For the ring line, only a falling edge sets its flag.

A modem-status interrupt request stays high for as long as any delta flag is set. Reading the status register clears the flags and leaves the line levels alone. When the loop bit in the control word is set, the status lines are taken from the control bits instead of the external inputs. This lets software test the handshake path without a cable, and the external inputs have no effect while loopback is on.

Top module: `modem_ctl_stat`

## Requirements
- R1: After a synchronous reset, `ctl_q` reads 0x08 (OUT2 only) and `stat_q` reads 0xB0: DCD (bit 7), DSR (bit 5) and CTS (bit 4) set, RI (bit 6) clear, and all delta bits (3:0) clear. `msi_req` is low.
- R2: When loopback is off, a level change on an external line shows in `stat_q[7:4]` three clock edges after it is applied. The mapping is DCD to bit 7, RI to bit 6, DSR to bit 5 and CTS to bit 4.
- R3: Any change of the recorded DCD, DSR or CTS level sets delta bit 3, 1 or 0 respectively, in the same cycle as the level bit updates.
- R4: Delta bit 2 is set only when the recorded RI level goes from 1 to 0. A 0-to-1 change of RI sets no delta bit.
- R5: Delta bits stay set until a read strobe `stat_rd`. A read clears all four delta bits one edge later and leaves bits 7:4 unchanged. A change recorded at the same edge as the read is kept.
- R6: A write strobe `ctl_wr` stores `ctl_wdata[4:0]` at the next edge. `ctl_q[7:5]` always read 0. The pins follow the stored bits: DTR = bit 0, RTS = bit 1, OUT1 = bit 2, OUT2 = bit 3.
- R7: While control bit 4 (loop) is set, `stat_q[7:4]` shows {OUT2, OUT1, DTR, RTS} from the control register one edge later. The external inputs are ignored, and changes caused through loopback set deltas by R3 and R4.
- R8: `msi_req` is high exactly when at least one of `stat_q[3:0]` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control word: loop, OUT2, OUT1, RTS, DTR (bits 4..0) |
| stat_rd | input | 1 | Status register read strobe, clears deltas |
| line_cts | input | 1 | External clear-to-send line |
| line_dsr | input | 1 | External data-set-ready line |
| line_dcd | input | 1 | External carrier-detect line |
| line_ri | input | 1 | External ring-indicator line |
| ctl_q | output | 8 | Control register read value |
| stat_q | output | 8 | Status register read value |
| pin_dtr | output | 1 | DTR output |
| pin_rts | output | 1 | RTS output |
| pin_out1 | output | 1 | OUT1 output |
| pin_out2 | output | 1 | OUT2 output |
| msi_req | output | 1 | Modem-status interrupt request |

## Verification
Directed patterns check the two directions of the ring line: a rising edge must leave the deltas clear, while a falling edge must set only bit 2. Another directed pattern lands a CTS change on the same edge as a read, to show the new event is not lost when the old flags are cleared. A loopback pattern toggles the external lines while loop is set, to show the status follows only the control bits. Random runs then mix line toggles, reads and control writes (with and without the loop bit), and every cycle is compared against a bench model of the register pipeline.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  localparam int REG_W = 8;
  localparam int CTL_W = 5;
  localparam int NLINE = 4;

  localparam int CTL_DTR  = 0;
  localparam int CTL_RTS  = 1;
  localparam int CTL_OUT1 = 2;
  localparam int CTL_OUT2 = 3;
  localparam int CTL_LOOP = 4;

  localparam logic [CTL_W-1:0] CTL_RST = 5'h08;

  // packed order matches status bits 7..4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } mdm_lines_t;

  localparam mdm_lines_t LINES_RST = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b1};

  function automatic mdm_lines_t loop_map(input logic [CTL_W-1:0] c);
    mdm_lines_t m;
    m.dcd = c[CTL_OUT2];
    m.ri  = c[CTL_OUT1];
    m.dsr = c[CTL_DTR];
    m.cts = c[CTL_RTS];
    return m;
  endfunction
endpackage

// File: rtl/mdm_sync.sv
module mdm_sync #(
  parameter int STAGES = 2,
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/mdm_ctl_reg.sv
module mdm_ctl_reg
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] ctl
);
  always_ff @(posedge clk) begin
    if (rst)     ctl <= CTL_RST;
    else if (wr) ctl <= wdata;
  end
endmodule

// File: rtl/mdm_status.sv
module mdm_status
  import mdm_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  mdm_lines_t       lines,
  input  logic             rd,
  output logic [REG_W-1:0] stat,
  output logic             irq
);
  mdm_lines_t       level_r;
  logic [NLINE-1:0] delta_r;
  logic [NLINE-1:0] delta_new;
  logic [NLINE-1:0] delta_nxt;

  always_comb begin
    delta_new[3] = lines.dcd ^ level_r.dcd;
    delta_new[2] = level_r.ri & ~lines.ri;
    delta_new[1] = lines.dsr ^ level_r.dsr;
    delta_new[0] = lines.cts ^ level_r.cts;
    delta_nxt    = (rd ? '0 : delta_r) | delta_new;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_r <= LINES_RST;
      delta_r <= '0;
      irq     <= 1'b0;
    end else begin
      level_r <= lines;
      delta_r <= delta_nxt;
      irq     <= |delta_nxt;
    end
  end

  assign stat = {level_r, delta_r};
endmodule

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat
  import mdm_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             stat_rd,
  input  logic             line_cts,
  input  logic             line_dsr,
  input  logic             line_dcd,
  input  logic             line_ri,
  output logic [REG_W-1:0] ctl_q,
  output logic [REG_W-1:0] stat_q,
  output logic             pin_dtr,
  output logic             pin_rts,
  output logic             pin_out1,
  output logic             pin_out2,
  output logic             msi_req
);
  localparam int PAD_W = REG_W - CTL_W;

  logic [CTL_W-1:0] ctl;
  mdm_lines_t       ext_raw, ext_sync, eff;

  assign ext_raw = '{dcd: line_dcd, ri: line_ri, dsr: line_dsr, cts: line_cts};

  mdm_sync #(.STAGES(SYNC_STAGES), .W(NLINE), .RST_VAL(LINES_RST)) u_sync (
    .clk(clk), .rst(rst), .d(ext_raw), .q(ext_sync)
  );

  mdm_ctl_reg u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata), .ctl(ctl)
  );

  assign eff = ctl[CTL_LOOP] ? loop_map(ctl) : ext_sync;

  mdm_status u_stat (
    .clk(clk), .rst(rst), .lines(eff), .rd(stat_rd), .stat(stat_q), .irq(msi_req)
  );

  assign ctl_q    = {{PAD_W{1'b0}}, ctl};
  assign pin_dtr  = ctl[CTL_DTR];
  assign pin_rts  = ctl[CTL_RTS];
  assign pin_out1 = ctl[CTL_OUT1];
  assign pin_out2 = ctl[CTL_OUT2];
endmodule

// File: rtl/modem_ctl_stat_chk.sv
module modem_ctl_stat_chk (
  input logic       clk,
  input logic       rst,
  input logic       stat_rd,
  input logic [7:0] ctl_q,
  input logic [7:0] stat_q,
  input logic       msi_req
);
  assert_reset_vals_R1: assert property (@(posedge clk)
    $past(rst) |-> (ctl_q == 8'h08 && stat_q == 8'hB0 && !msi_req));

  assert_dcd_delta_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(stat_q[7])) |-> stat_q[3]);

  assert_cts_delta_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(stat_q[4])) |-> stat_q[0]);

  assert_teri_fall_only_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(stat_q[2])) |-> $fell(stat_q[6]));

  assert_delta_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> ((stat_q[3:0] & $past(stat_q[3:0])) == $past(stat_q[3:0])));

  assert_ctl_pad_zero_R6: assert property (@(posedge clk) disable iff (rst)
    ctl_q[7:5] == 3'b000);

  assert_loop_map_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl_q[4])) |->
      stat_q[7:4] == {$past(ctl_q[3]), $past(ctl_q[2]), $past(ctl_q[0]), $past(ctl_q[1])});

  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    msi_req == (stat_q[3:0] != 4'b0000));
endmodule

bind modem_ctl_stat modem_ctl_stat_chk u_chk (
  .clk(clk), .rst(rst), .stat_rd(stat_rd), .ctl_q(ctl_q), .stat_q(stat_q), .msi_req(msi_req)
);

// File: tb/tb_modem_ctl_stat.sv
`timescale 1ns/1ps
module tb_modem_ctl_stat;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = 5'h00;
  logic       stat_rd = 1'b0;
  logic       line_cts = 1'b1, line_dsr = 1'b1, line_dcd = 1'b1, line_ri = 1'b0;
  logic [7:0] ctl_q, stat_q;
  logic       pin_dtr, pin_rts, pin_out1, pin_out2, msi_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // reference state, predicts values after the next edge
  logic [3:0] m_s1, m_s2, m_up, m_dl;
  logic [4:0] m_ctl;
  logic       m_irq;

  always #4 clk = ~clk;

  modem_ctl_stat dut (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .stat_rd(stat_rd),
    .line_cts(line_cts), .line_dsr(line_dsr), .line_dcd(line_dcd), .line_ri(line_ri),
    .ctl_q(ctl_q), .stat_q(stat_q), .pin_dtr(pin_dtr), .pin_rts(pin_rts),
    .pin_out1(pin_out1), .pin_out2(pin_out2), .msi_req(msi_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] eff_lines(input logic [4:0] c, input logic [3:0] s);
    return c[4] ? {c[3], c[2], c[0], c[1]} : s;
  endfunction

  task automatic model_adv();
    logic [3:0] e, dn, nd;
    if (rst) begin
      m_s1 = 4'b1011; m_s2 = 4'b1011; m_up = 4'b1011; m_dl = 4'b0000;
      m_ctl = 5'h08; m_irq = 1'b0;
    end else begin
      e  = eff_lines(m_ctl, m_s2);
      dn = {e[3] ^ m_up[3], m_up[2] & ~e[2], e[1] ^ m_up[1], e[0] ^ m_up[0]};
      nd = (stat_rd ? 4'b0000 : m_dl) | dn;
      m_up = e; m_dl = nd; m_irq = |nd;
      m_s2 = m_s1;
      m_s1 = {line_dcd, line_ri, line_dsr, line_cts};
      if (ctl_wr) m_ctl = ctl_wdata;
    end
  endtask

  task automatic compare();
    chk(m_ctl[4] ? "R7 level" : "R2 level", {4'h0, stat_q[7:4]}, {4'h0, m_up});
    chk("R3 delta", {5'h0, stat_q[3], stat_q[1:0]}, {5'h0, m_dl[3], m_dl[1:0]});
    chk("R4 ring delta", {7'h0, stat_q[2]}, {7'h0, m_dl[2]});
    chk("R6 ctl", ctl_q, {3'b000, m_ctl});
    chk("R6 pins", {4'h0, pin_out2, pin_out1, pin_rts, pin_dtr}, {4'h0, m_ctl[3:0]});
    chk("R8 irq", {7'h0, msi_req}, {7'h0, m_irq});
  endtask

  task automatic tick();
    model_adv();
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    tick(); tick();
    rst = 1'b0;
    tick();
    // R1: reset values
    chk("R1 stat", stat_q, 8'hB0);
    chk("R1 ctl", ctl_q, 8'h08);
    chk("R1 irq", {7'h0, msi_req}, 8'h00);

    // R4: rising ring edge gives no delta
    line_ri = 1'b1;
    repeat (3) tick();
    chk("R4 rise no delta", stat_q, 8'hF0);
    line_ri = 1'b0;
    repeat (3) tick();
    chk("R4 fall sets bit2", stat_q, 8'hB4);

    // R5: CTS change lands on the same edge as a read
    line_cts = 1'b0;
    tick(); tick();
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    chk("R5 coincident kept", stat_q, 8'hA1);
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    chk("R5 read clears", stat_q, 8'hA0);
    tick();
    chk("R5 stays clear", stat_q, 8'hA0);

    // R7: loopback with OUT1 and DTR
    ctl_wr = 1'b1; ctl_wdata = 5'b1_0101;
    tick();
    ctl_wr = 1'b0;
    chk("R6 write", ctl_q, 8'h15);
    tick();
    chk("R7 loop map", stat_q, 8'h68);
    for (int i = 0; i < 8; i++) begin
      {line_dcd, line_ri, line_dsr, line_cts} = 4'(i * 5 + 3);
      tick();
      chk("R7 ext ignored", {4'h0, stat_q[7:4]}, 8'h06);
    end
    ctl_wr = 1'b1; ctl_wdata = 5'h08;
    tick();
    ctl_wr = 1'b0;
    stat_rd = 1'b1;
    repeat (4) tick();
    stat_rd = 1'b0;

    // random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 3) == 0)
        {line_dcd, line_ri, line_dsr, line_cts} = 4'($urandom());
      stat_rd = ($urandom_range(0, 5) == 0);
      ctl_wr  = ($urandom_range(0, 15) == 0);
      ctl_wdata = 5'($urandom());
      if ($urandom_range(0, 3) != 0) ctl_wdata[4] = 1'b0;
      tick();
    end
    ctl_wr = 1'b0; stat_rd = 1'b0;

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule